// File: doc/BRIEF.md
# Four-Channel Converter Serial Slave

This block is the device side of a four-wire serial link for a sampling converter that has four analog sources behind one multiplexer. A host lowers an active-low select, then toggles a serial clock for exactly sixteen cycles. On the falling edges of that clock the block shifts out the previous conversion result and, over the same edges, shifts in a 12-bit control word. The result is preceded by two zero bits and a 2-bit tag that names the channel it came from. The control word is write-only. It chooses the channel and the output number format for the next frame, so results and configuration run one frame apart.

All pins are sampled into one system clock domain through a synchronizer chain. The serial data output is modelled as a value plus an enable. The converter itself is outside the block. Its parallel sample arrives on `smp_data` for whichever channel `chan_sel` currently points at, and the block captures it when a frame opens.

Top module: `spi_cvt_slave`

## Requirements
- R1: After reset the output enable is low, `chan_sel` is 00 and the coding is straight binary, so the first frame returns channel 00 with its sample unchanged.
- R2: Once the select falls, the output is driven before the first falling clock edge and stays driven through all sixteen bits. The sixteen bits are, in order: 0, 0, tag bit 1, tag bit 0, then the 12-bit result with its MSB first.
- R3: The output enable drops after the 16th falling edge, while the select is still low.
- R4: The DIN bits on falling edges 1 to 12 form the control word, MSB first. Word bit 11 is the write flag, bits 7:6 are the channel (00 rate, 01 temperature, 10 auxiliary 1, 11 auxiliary 2), and bit 0 is the coding (1 straight binary, 0 two's complement).
- R5: When the write flag is 0, the control register keeps its contents. The next frame shows the same tag and coding, and `chan_sel` does not move.
- R6: DIN on falling edges 13 to 16 has no effect on the register.
- R7: A written channel reaches `chan_sel` through the 14th falling edge and not through any earlier one.
- R8: With two's complement coding, the result is the sample with its MSB inverted.
- R9: If the select rises before 16 falling edges, the output enable drops, the register is not updated and `chan_sel` returns to the channel held in the register.
- R10: A completed write takes effect in the next frame. That frame returns the new channel's tag and that channel's sample in the new coding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Host serial clock, idles high |
| din | input | 1 | Serial control input |
| smp_data | input | 12 | Parallel sample from the converter for the selected channel |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output drive enable; low means high impedance |
| chan_sel | output | 2 | Channel select to the analog multiplexer |

## Verification
Two pairs of functions can land on the same system clock cycle. On the 16th falling edge, the commit of the control register and the release of the output happen together. The bench checks both: the enable must be low before the select rises, and the next frame must carry the committed tag and coding. The harder case is a select that rises after 15 edges. By then the multiplexer has already moved to a pending channel, so the abort has to undo that move and also cancel the commit that would otherwise follow. The bench judges this by checking that `chan_sel` returns to the old channel and that the following frame still reports the old tag.

// File: rtl/spi_cvt_pkg.sv
package spi_cvt_pkg;

    localparam int DATA_W    = 12;
    localparam int TAG_W     = 2;
    localparam int FRAME_LEN = 2 + TAG_W + DATA_W;
    localparam int CTRL_W    = 12;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    // falling-edge numbers that carry meaning inside a frame
    localparam int EDGE_WR   = 1;
    localparam int EDGE_CFG  = CTRL_W;
    localparam int EDGE_MUX  = 14;

    typedef enum logic [TAG_W-1:0] {
        CH_RATE = 2'b00,
        CH_TEMP = 2'b01,
        CH_AUX1 = 2'b10,
        CH_AUX2 = 2'b11
    } chan_e;

    // the eleven stored bits of the control word (word bits 10..0)
    typedef struct packed {
        logic       rsv_lo10;
        logic [1:0] free_hi;
        chan_e      chan;
        logic [1:0] rsv_hi;
        logic [1:0] free_lo;
        logic       rsv_lo1;
        logic       coding_bin;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        rsv_lo10:   1'b0,
        free_hi:    2'b00,
        chan:       CH_RATE,
        rsv_hi:     2'b11,
        free_lo:    2'b00,
        rsv_lo1:    1'b0,
        coding_bin: 1'b1
    };

    function automatic logic [DATA_W-1:0] apply_coding(
        input logic [DATA_W-1:0] raw,
        input logic              straight
    );
        apply_coding = straight ? raw : {~raw[DATA_W-1], raw[DATA_W-2:0]};
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_word(
        input chan_e             tag,
        input logic [DATA_W-1:0] value
    );
        build_word = {2'b00, tag, value};
    endfunction

endpackage

// File: rtl/spi_cvt_sync.sv
module spi_cvt_sync
    #(parameter int STAGES = 2)
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic din_i,
    output logic cs_fall,
    output logic cs_rise,
    output logic sclk_fall,
    output logic din_s
);

    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] din_q;
    logic              cs_d;
    logic              sclk_d;
    logic              cs_s;
    logic              sclk_s;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    cs_q[g]   <= 1'b1;
                    sclk_q[g] <= 1'b1;
                    din_q[g]  <= 1'b0;
                end else begin
                    cs_q[g]   <= cs_n_i;
                    sclk_q[g] <= sclk_i;
                    din_q[g]  <= din_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    cs_q[g]   <= 1'b1;
                    sclk_q[g] <= 1'b1;
                    din_q[g]  <= 1'b0;
                end else begin
                    cs_q[g]   <= cs_q[g-1];
                    sclk_q[g] <= sclk_q[g-1];
                    din_q[g]  <= din_q[g-1];
                end
            end
        end
    end

    assign cs_s   = cs_q[STAGES-1];
    assign sclk_s = sclk_q[STAGES-1];
    assign din_s  = din_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b1;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_d & ~cs_s;
    assign cs_rise   = ~cs_d & cs_s;
    assign sclk_fall = sclk_d & ~sclk_s & ~cs_s;

endmodule

// File: rtl/spi_cvt_frame.sv
module spi_cvt_frame
    import spi_cvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_fall,
    input  logic             din_s,
    output logic             fall_ev,
    output logic [CNT_W-1:0] fall_no,
    output ctrl_t            ctrl_q,
    output chan_e            mux_q
);

    logic [CNT_W-1:0]  cnt;
    logic              inframe;
    logic              wr_en;
    logic [CTRL_W-2:0] shadow;
    ctrl_t             shadow_view;

    assign shadow_view = ctrl_t'(shadow);
    assign fall_ev     = sclk_fall & inframe & (cnt < CNT_W'(FRAME_LEN));
    assign fall_no     = cnt + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            inframe <= 1'b0;
            wr_en   <= 1'b0;
            shadow  <= '0;
            ctrl_q  <= CTRL_RESET;
            mux_q   <= CH_RATE;
        end else if (cs_rise) begin
            // frame cut short: drop the shadow, put the mux back
            if (inframe) begin
                inframe <= 1'b0;
                mux_q   <= ctrl_q.chan;
            end
        end else if (cs_fall) begin
            cnt     <= '0;
            inframe <= 1'b1;
            wr_en   <= 1'b0;
        end else if (fall_ev) begin
            cnt <= fall_no;
            if (fall_no == CNT_W'(EDGE_WR)) begin
                wr_en <= din_s;
            end else if (fall_no <= CNT_W'(EDGE_CFG)) begin
                shadow <= {shadow[CTRL_W-3:0], din_s};
            end
            if (fall_no == CNT_W'(EDGE_MUX) && wr_en) begin
                mux_q <= shadow_view.chan;
            end
            if (fall_no == CNT_W'(FRAME_LEN)) begin
                inframe <= 1'b0;
                if (wr_en) begin
                    ctrl_q <= shadow_view;
                end
            end
        end
    end

endmodule

// File: rtl/spi_cvt_tx.sv
module spi_cvt_tx
    import spi_cvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              fall_ev,
    input  logic [CNT_W-1:0]  fall_no,
    input  logic [DATA_W-1:0] sample,
    input  chan_e             tag,
    input  logic              coding_bin,
    output logic              dout,
    output logic              dout_oe
);

    logic [FRAME_LEN-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) begin
            word    <= '0;
            dout_oe <= 1'b0;
        end else if (cs_rise) begin
            dout_oe <= 1'b0;
        end else if (cs_fall) begin
            word    <= build_word(tag, apply_coding(sample, coding_bin));
            dout_oe <= 1'b1;
        end else if (fall_ev && dout_oe) begin
            if (fall_no == CNT_W'(FRAME_LEN)) begin
                dout_oe <= 1'b0;
            end else begin
                word <= {word[FRAME_LEN-2:0], 1'b0};
            end
        end
    end

    assign dout = dout_oe & word[FRAME_LEN-1];

endmodule

// File: rtl/spi_cvt_slave.sv
module spi_cvt_slave
    import spi_cvt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [DATA_W-1:0] smp_data,
    output logic              dout,
    output logic              dout_oe,
    output logic [TAG_W-1:0]  chan_sel
);

    logic             cs_fall;
    logic             cs_rise;
    logic             sclk_fall;
    logic             din_s;
    logic             fall_ev;
    logic [CNT_W-1:0] fall_no;
    ctrl_t            ctrl_q;
    chan_e            mux_q;

    spi_cvt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .cs_n_i    (cs_n),
        .sclk_i    (sclk),
        .din_i     (din),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s)
    );

    spi_cvt_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s),
        .fall_ev   (fall_ev),
        .fall_no   (fall_no),
        .ctrl_q    (ctrl_q),
        .mux_q     (mux_q)
    );

    spi_cvt_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .fall_ev    (fall_ev),
        .fall_no    (fall_no),
        .sample     (smp_data),
        .tag        (ctrl_q.chan),
        .coding_bin (ctrl_q.coding_bin),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );

    assign chan_sel = mux_q;

endmodule

// File: rtl/spi_cvt_chk.sv
module spi_cvt_chk
    import spi_cvt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_fall,
    input logic             cs_rise,
    input logic             fall_ev,
    input logic [CNT_W-1:0] fall_no,
    input logic             dout_oe,
    input logic [TAG_W-1:0] chan_sel,
    input logic [CTRL_W-2:0] ctrl_bits
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dout_oe && chan_sel == 2'b00 && ctrl_bits[0]));

    a_r2_drive_on_select: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> $past(cs_fall));

    a_r3_release_after_last: assert property (@(posedge clk) disable iff (rst)
        (fall_ev && fall_no == CNT_W'(FRAME_LEN)) |=> !dout_oe);

    a_r5_ctrl_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_bits) |-> $past(fall_ev && fall_no == CNT_W'(FRAME_LEN)));

    a_r7_mux_moves_on_edge14: assert property (@(posedge clk) disable iff (rst)
        !$stable(chan_sel) |-> $past((fall_ev && fall_no == CNT_W'(EDGE_MUX)) || cs_rise));

    a_r9_release_on_abort: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> !dout_oe);

endmodule

bind spi_cvt_slave spi_cvt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .fall_ev   (fall_ev),
    .fall_no   (fall_no),
    .dout_oe   (dout_oe),
    .chan_sel  (chan_sel),
    .ctrl_bits (ctrl_q)
);

// File: tb/spi_cvt_slave_tb_top.sv
module spi_cvt_slave_tb_top;

    localparam int H = 6;   // system clocks per serial clock half period

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic [11:0] smp_data;
    logic [11:0] salt = 12'h000;
    logic        dout;
    logic        dout_oe;
    logic [1:0]  chan_sel;

    int n_chk = 0;
    int n_fail = 0;

    logic [1:0] m_chan = 2'b00;
    logic       m_bin = 1'b1;

    always #5 clk = ~clk;

    function automatic logic [11:0] base_of(input logic [1:0] ch);
        case (ch)
            2'b00:   base_of = 12'h8A5;
            2'b01:   base_of = 12'h3C1;
            2'b10:   base_of = 12'hF00;
            default: base_of = 12'h07E;
        endcase
    endfunction

    always_comb smp_data = base_of(chan_sel) ^ salt;

    spi_cvt_slave dut_i (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .din      (din),
        .smp_data (smp_data),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .chan_sel (chan_sel)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] mk_ctl(input logic wr, input logic [1:0] ch,
                                           input logic bin);
        mk_ctl = {wr, 1'b0, 2'b00, ch, 2'b11, 2'b00, 1'b0, bin};
    endfunction

    // one frame; nedge < 16 cuts it short
    task automatic frame(input logic [11:0] ctl, input logic [3:0] tail,
                         input int nedge, input string req);
        logic [15:0] got;
        logic [15:0] expw;
        logic [11:0] s;
        logic [1:0]  mux_log [1:16];
        logic [1:0]  nxt;
        logic        oe_bad;
        got    = '0;
        oe_bad = 1'b0;
        s      = base_of(m_chan) ^ salt;
        expw   = {2'b00, m_chan, m_bin ? s : {~s[11], s[10:0]}};
        nxt    = ctl[11] ? ctl[7:6] : m_chan;
        for (int k = 1; k <= 16; k++) mux_log[k] = 2'bxx;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 1; i <= nedge; i++) begin
            din = (i <= 12) ? ctl[12-i] : tail[16-i];
            repeat (H) @(negedge clk);
            got[16-i]  = dout;
            if (!dout_oe) oe_bad = 1'b1;
            mux_log[i] = chan_sel;
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (H) @(negedge clk);
        if (nedge == 16) begin
            chk("R2", "enable held over frame", 32'(oe_bad), 32'd0);
            chk(req, "frame word", 32'(got), 32'(expw));
            chk("R3", "enable after 16th edge", 32'(dout_oe), 32'd0);
            chk("R7", "mux before 14th edge", 32'(mux_log[14]), 32'(m_chan));
            chk("R7", "mux after 14th edge", 32'(mux_log[15]), 32'(nxt));
            cs_n = 1'b1;
            if (ctl[11]) begin
                m_chan = ctl[7:6];
                m_bin  = ctl[0];
            end
        end else begin
            cs_n = 1'b1;
            repeat (H) @(negedge clk);
            chk("R9", "enable after early release", 32'(dout_oe), 32'd0);
            chk("R9", "mux restored", 32'(chan_sel), 32'(m_chan));
        end
        din = 1'b0;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "enable after reset", 32'(dout_oe), 32'd0);
        chk("R1", "mux after reset", 32'(chan_sel), 32'd0);
    endtask

    task automatic t_no_write;
        frame(mk_ctl(1'b0, 2'b11, 1'b0), 4'h0, 16, "R1");   // default straight, ch 00
        frame(mk_ctl(1'b1, 2'b01, 1'b0), 4'hF, 16, "R5");   // previous frame wrote nothing
    endtask

    task automatic t_twos_and_tail;
        salt = 12'h5A3;
        frame(mk_ctl(1'b1, 2'b10, 1'b1), 4'hA, 16, "R8");   // ch 01 two's complement
    endtask

    task automatic t_abort;
        frame(mk_ctl(1'b1, 2'b11, 1'b0), 4'hF, 15, "R9");   // after mux already moved
        frame(mk_ctl(1'b1, 2'b11, 1'b0), 4'h0, 5, "R9");    // early
        frame(mk_ctl(1'b0, 2'b00, 1'b0), 4'h0, 16, "R6");   // still ch 10 straight: R6, R9
    endtask

    task automatic t_next_frame;
        salt = 12'h0F0;
        frame(mk_ctl(1'b1, 2'b00, 1'b0), 4'h0, 16, "R10");
        frame(mk_ctl(1'b1, 2'b11, 1'b1), 4'h5, 16, "R4");   // ch 00 two's complement
        frame(mk_ctl(1'b0, 2'b00, 1'b0), 4'h0, 16, "R10");  // ch 11 straight
    endtask

    initial begin
        t_reset();
        t_no_write();
        t_twos_and_tail();
        t_abort();
        t_next_frame();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule